// File: doc/BRIEF.md
# Decimating FIR Filter with RAM Coefficients and a Circular Delay Line

This block filters an I/Q sample pair stream with a programmable finite impulse response and decimates the result. Coefficients sit in a 256-entry coefficient memory. Incoming samples go into a circular delay-line memory, one memory per lane. A single multiply-accumulate engine walks the taps one per clock, with I and Q handled side by side. Several filters can be held in the coefficient memory at once. A base-offset register picks the active filter, so switching filters takes one register write.

Every M-th accepted sample starts a pass over the newest NTAPS stored samples. At the end of the pass, the wide accumulator is shifted by a programmable power of two and rounded to nearest. It is then clamped to a signed 16-bit word and presented with a one-cycle valid strobe. If a decimated trigger arrives while a pass is still running, the block flags an overrun.

Top module: `decimFir`

## Requirements
- R1: A write with `cfgAddr[8]`=0 stores `cfgData` as a 20-bit two's complement coefficient at address `cfgAddr[7:0]`. A write with `cfgAddr[8]`=1 writes a control register chosen by `cfgAddr[1:0]`: 0 = taps minus one (8 bits), 1 = coefficient base offset (8 bits), 2 = decimation ratio minus one (5 bits, ratio 1..32), 3 = scale (3 bits).
- R2: While `rstN` is low and after its release, `outValid` and `overrun` are 0 and both outputs are 0. Reset sets one tap, offset 0, ratio 1 and scale 0.
- R3: For the 256 cycles after reset release, the delay line is zero-filled and `inValid` is ignored. A later pass that reaches back past the first accepted sample therefore sees zeros.
- R4: Each accepted sample adds one to a phase count. A pass starts on the sample that makes the count reach M, and the count then restarts. Writing the ratio register also restarts the count.
- R5: A pass with N taps and offset F computes the sum over k = 0..N-1 of coef[F+k] times sample(newest-(N-1)+k). The oldest sample pairs with coef[F] and the newest with coef[F+N-1].
- R6: Rewriting only the offset register switches the next pass to a different coefficient set, without rewriting any coefficient.
- R7: With shift s = 26 - scale, the output is (acc + 2^(s-1)) >> s, using an arithmetic shift.
- R8: A rounded value above 32767 or below -32768 is clamped to that limit.
- R9: If the triggering sample is taken at clock edge T, the tap products enter the accumulator at edges T+1..T+N. `outValid` is then high for exactly the one cycle after edge T+N+1.
- R10: A trigger during edges T+1..T+N raises `overrun` for the one cycle after that edge. That trigger starts no pass, and the running pass completes unchanged.
- R11: I and Q use the same coefficients and produce independent results in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 9 | Coefficient address or control register select |
| cfgData | input | 20 | Coefficient or register value |
| inValid | input | 1 | Input sample qualifier |
| inI | input | 18 | In-phase sample, signed |
| inQ | input | 18 | Quadrature sample, signed |
| outValid | output | 1 | One-cycle result strobe |
| outI | output | 16 | Rounded in-phase result, signed |
| outQ | output | 16 | Rounded quadrature result, signed |
| overrun | output | 1 | One-cycle pulse when a trigger hits a running pass |

## Verification
The bench uses the package defaults: 256-deep memories, 18-bit samples, 20-bit coefficients and a 5-bit ratio field. With these values a filter can sit at the top of the coefficient memory (offset 240, 16 taps), and a ratio of 32 can be tested. A full-scale coefficient times a full-scale sample can be driven hard into both clamps at the top scale setting. Short filters at ratio 1 with back-to-back samples produce triggers that land on every cycle of a running pass, which exercises the overrun path.

// File: rtl/firPkg.sv
package firPkg;
  localparam int DATA_W     = 18;
  localparam int COEF_W     = 20;
  localparam int OUT_W      = 16;
  localparam int DEPTH      = 256;
  localparam int LANES      = 2;
  localparam int DEC_W      = 5;
  localparam int SCALE_W    = 3;
  localparam int ROUND_BASE = 26;
  localparam int PTR_W      = $clog2(DEPTH);
  localparam int ADDR_W     = PTR_W + 1;
  localparam int PROD_W     = DATA_W + COEF_W;
  localparam int ACC_W      = PROD_W + PTR_W;

  localparam logic signed [ACC_W:0] SAT_HI = (ACC_W+1)'(2**(OUT_W-1) - 1);
  localparam logic signed [ACC_W:0] SAT_LO = -SAT_HI - 1;

  typedef struct packed {
    logic             wrEn;
    logic             wrZero;
    logic [PTR_W-1:0] wrAddr;
    logic             clearAcc;
    logic             macEn;
    logic [PTR_W-1:0] rdAddr;
    logic [PTR_W-1:0] coefAddr;
    logic             loadOut;
  } strobeT;

  function automatic logic signed [OUT_W-1:0] roundSat(
      input logic signed [ACC_W-1:0] acc, input logic [SCALE_W-1:0] sc);
    logic signed [ACC_W:0] wide;
    logic signed [ACC_W:0] shifted;
    int amt;
    amt     = ROUND_BASE - int'(sc);
    wide    = {acc[ACC_W-1], acc} + ((ACC_W+1)'(1) << (amt - 1));
    shifted = wide >>> amt;
    if (shifted > SAT_HI) return SAT_HI[OUT_W-1:0];
    if (shifted < SAT_LO) return SAT_LO[OUT_W-1:0];
    return shifted[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/firCtrl.sv
module firCtrl import firPkg::*; (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [COEF_W-1:0]  cfgData,
  input  logic               inValid,
  output strobeT             stb,
  output logic [SCALE_W-1:0] scale,
  output logic               busy,
  output logic               clearing,
  output logic               overrun
);
  logic [PTR_W-1:0] tapsM1, offset, wrPtr, clrCnt, tap, base;
  logic [DEC_W-1:0] decM1, decCnt;
  logic             doneQ;

  logic regWr, accept, trig, start;
  assign regWr  = cfgWrEn && cfgAddr[ADDR_W-1];
  assign accept = inValid && !clearing;
  assign trig   = accept && (decCnt >= decM1);
  assign start  = trig && !busy;

  always_comb begin
    stb.wrEn     = accept || clearing;
    stb.wrZero   = clearing;
    stb.wrAddr   = clearing ? clrCnt : wrPtr;
    stb.clearAcc = start;
    stb.macEn    = busy;
    stb.rdAddr   = base + tap;
    stb.coefAddr = offset + tap;
    stb.loadOut  = doneQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapsM1 <= '0;
      offset <= '0;
      decM1  <= '0;
      scale  <= '0;
    end else if (regWr) begin
      case (cfgAddr[1:0])
        2'd0: tapsM1 <= cfgData[PTR_W-1:0];
        2'd1: offset <= cfgData[PTR_W-1:0];
        2'd2: decM1  <= cfgData[DEC_W-1:0];
        default: scale <= cfgData[SCALE_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clearing <= 1'b1;
      clrCnt   <= '0;
      wrPtr    <= '0;
      decCnt   <= '0;
    end else begin
      if (clearing) begin
        clrCnt <= clrCnt + 1'b1;
        if (clrCnt == PTR_W'(DEPTH - 1)) clearing <= 1'b0;
      end
      if (accept) wrPtr <= wrPtr + 1'b1;
      if (regWr && cfgAddr[1:0] == 2'd2) decCnt <= '0;
      else if (accept) decCnt <= trig ? '0 : decCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      doneQ   <= 1'b0;
      overrun <= 1'b0;
      tap     <= '0;
      base    <= '0;
    end else begin
      overrun <= trig && busy;
      doneQ   <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        tap  <= '0;
        base <= wrPtr - tapsM1;
      end else if (busy) begin
        if (tap == tapsM1) begin
          busy  <= 1'b0;
          doneQ <= 1'b1;
        end else begin
          tap <= tap + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/firDatapath.sv
module firDatapath import firPkg::*; (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     coefWe,
  input  logic [PTR_W-1:0]         coefWrAddr,
  input  logic signed [COEF_W-1:0] coefWrData,
  input  logic signed [DATA_W-1:0] laneIn [LANES],
  input  strobeT                   stb,
  input  logic [SCALE_W-1:0]       scale,
  output logic                     outValid
);
  logic signed [COEF_W-1:0] coefMem [DEPTH];
  logic signed [COEF_W-1:0] coefRd;

  always_ff @(posedge clk) begin
    if (coefWe) coefMem[coefWrAddr] <= coefWrData;
  end
  assign coefRd = coefMem[stb.coefAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= stb.loadOut;
  end

  for (genvar L = 0; L < LANES; L++) begin : gLane
    logic signed [DATA_W-1:0] dataMem [DEPTH];
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc;
    logic signed [OUT_W-1:0]  res;

    always_ff @(posedge clk) begin
      if (stb.wrEn) dataMem[stb.wrAddr] <= stb.wrZero ? '0 : laneIn[L];
    end

    assign prod = dataMem[stb.rdAddr] * coefRd;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        acc <= '0;
        res <= '0;
      end else begin
        if (stb.clearAcc)  acc <= '0;
        else if (stb.macEn) acc <= acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        if (stb.loadOut)   res <= roundSat(acc, scale);
      end
    end
  end
endmodule

// File: rtl/decimFir.sv
module decimFir import firPkg::*; (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWrEn,
  input  logic [ADDR_W-1:0]        cfgAddr,
  input  logic [COEF_W-1:0]        cfgData,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outI,
  output logic signed [OUT_W-1:0]  outQ,
  output logic                     overrun
);
  strobeT                   stb;
  logic [SCALE_W-1:0]       scale;
  logic                     busy, clearing;
  logic signed [DATA_W-1:0] laneIn [LANES];

  assign laneIn[0] = inI;
  assign laneIn[1] = inQ;

  firCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .inValid(inValid), .stb(stb), .scale(scale),
    .busy(busy), .clearing(clearing), .overrun(overrun)
  );

  firDatapath dp_i (
    .clk(clk), .rstN(rstN),
    .coefWe(cfgWrEn && !cfgAddr[ADDR_W-1]),
    .coefWrAddr(cfgAddr[PTR_W-1:0]),
    .coefWrData(cfgData),
    .laneIn(laneIn), .stb(stb), .scale(scale), .outValid(outValid)
  );

  assign outI = dp_i.gLane[0].res;
  assign outQ = dp_i.gLane[1].res;
endmodule

// File: rtl/firChecker.sv
module firChecker (
  input logic clk,
  input logic rstN,
  input logic outValid,
  input logic overrun,
  input logic busy,
  input logic clearing
);
  AST_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R9
  AST_OUT_AFTER_PASS: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(busy, 2) && !$past(busy))); // R9
  AST_OVR_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> $past(busy)); // R10
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    clearing |-> (!busy && !outValid)); // R3
endmodule

bind decimFir firChecker chk_i (
  .clk(clk), .rstN(rstN), .outValid(outValid), .overrun(overrun),
  .busy(busy), .clearing(clearing)
);

// File: tb/decimFir_tb_top.sv
`timescale 1ns/1ps
module decimFir_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [8:0] cfgAddr = '0;
  logic [19:0] cfgData = '0;
  logic inValid = 1'b0;
  logic signed [17:0] inI = '0, inQ = '0;
  logic outValid, overrun;
  logic signed [15:0] outI, outQ;

  always #10 clk = ~clk;

  decimFir dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .inValid(inValid), .inI(inI), .inQ(inQ),
    .outValid(outValid), .outI(outI), .outQ(outQ), .overrun(overrun)
  );

  typedef struct packed {
    int tapsM1; int off; int decM1; int scale; int nOut;
  } caseT;
  localparam caseT CASES [6] = '{
    '{0, 0, 0, 7, 4},
    '{2, 10, 1, 5, 3},
    '{7, 100, 3, 7, 3},
    '{15, 240, 7, 6, 2},
    '{4, 0, 31, 0, 2},
    '{1, 20, 2, 7, 3}
  };

  int nChk = 0, nFail = 0, cyc = 0, sIdx = 0;
  bit done = 0;
  int coefM [256];
  int histI[$], histQ[$];
  int qI[$], qQ[$], qCyc[$];
  int mTaps = 1, mOff = 0, mDec = 1, mScale = 0, mCnt = 0, busyUntil = -1;
  string curTag = "";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int rndSat(input longint acc, input int sc);
    int sh = 26 - sc;
    longint v = (acc + (longint'(1) <<< (sh - 1))) >>> sh;
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int coefFn(input int a);
    return ((a * 173 + 29) % 4001) - 2000;
  endfunction

  function automatic int smpI(input int i);
    return ((i * 7919 + 13) % 60001) - 30000;
  endfunction

  function automatic int smpQ(input int i);
    return ((i * 104729 + 7) % 50001) - 25000;
  endfunction

  // R1: register map; called just after a falling edge
  task automatic writeCfg(input int addr, input int data);
    cfgWrEn = 1'b1; cfgAddr = addr[8:0]; cfgData = data[19:0];
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (addr < 256) coefM[addr] = data;
    else case (addr - 256)
      0: mTaps = data + 1;
      1: mOff = data;
      2: begin mDec = data + 1; mCnt = 0; end
      default: mScale = data;
    endcase
  endtask

  task automatic setFilter(input int tapsM1, input int off, input int decM1, input int sc);
    writeCfg(256, tapsM1);
    writeCfg(257, off);
    writeCfg(258, decM1);
    writeCfg(259, sc);
  endtask

  // called just after a falling edge
  task automatic pushSample(input int vi, input int vq, input int idleN);
    bit trig, ovr;
    longint aI, aQ;
    inValid = 1'b1; inI = vi[17:0]; inQ = vq[17:0];
    @(posedge clk); #1;
    histI.push_back(vi); histQ.push_back(vq);
    trig = (mCnt + 1 >= mDec);
    mCnt = trig ? 0 : mCnt + 1;
    ovr = 0;
    if (trig) begin
      if (cyc <= busyUntil) ovr = 1;
      else begin
        busyUntil = cyc + mTaps;
        aI = 0; aQ = 0;
        for (int k = 0; k < mTaps; k++) begin
          int j = histI.size() - mTaps + k;
          if (j >= 0) begin
            aI += longint'(coefM[(mOff + k) % 256]) * histI[j];
            aQ += longint'(coefM[(mOff + k) % 256]) * histQ[j];
          end
        end
        qI.push_back(rndSat(aI, mScale));
        qQ.push_back(rndSat(aQ, mScale));
        qCyc.push_back(cyc + mTaps + 1);
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    if (trig) chk({curTag, " R10 overrun flag"}, int'(overrun), int'(ovr));
    repeat (idleN) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (qI.size() == 0) chk({curTag, " R4 unexpected output"}, 1, 0);
      else begin
        chk({curTag, " R5 output I"}, int'(outI), qI.pop_front());
        chk({curTag, " R11 output Q"}, int'(outQ), qQ.pop_front());
        chk({curTag, " R9 latency"}, cyc, qCyc.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++; nChk++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset outValid", int'(outValid), 0);
    chk("R2 reset overrun", int'(overrun), 0);
    chk("R2 reset outI", int'(outI), 0);
    chk("R2 reset outQ", int'(outQ), 0);
    rstN = 1'b1;
    // R3: samples offered during the clear sweep must be dropped
    repeat (20) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      inValid = 1'b1; inI = 18'sd90000; inQ = -18'sd90000;
      @(negedge clk);
    end
    inValid = 1'b0;
    repeat (300) @(negedge clk);
    chk("R3 no output after clear", int'(outValid), 0);

    // R2: reset defaults (one tap, offset 0, ratio 1, scale 0)
    curTag = "R2 defaults";
    writeCfg(0, 262144);
    pushSample(100000, -70000, 4);

    // R1 coefficient fill, then R3 zeros behind the first samples
    for (int a = 0; a < 256; a++) writeCfg(a, coefFn(a));
    curTag = "R3 cleared history";
    setFilter(7, 0, 0, 7);
    pushSample(120000, 50000, 10);

    // table of cases
    for (int c = 0; c < 6; c++) begin
      curTag = $sformatf("R1/R5 case%0d", c);
      setFilter(CASES[c].tapsM1, CASES[c].off, CASES[c].decM1, CASES[c].scale);
      for (int o = 0; o < CASES[c].nOut; o++)
        for (int s = 0; s <= CASES[c].decM1; s++) begin
          pushSample(smpI(sIdx), smpQ(sIdx), CASES[c].tapsM1 + 2);
          sIdx++;
        end
    end

    // R6: switch filter by offset only
    curTag = "R6 offset switch";
    setFilter(3, 40, 0, 7);
    pushSample(20000, -15000, 6);
    writeCfg(257, 60);
    pushSample(-8000, 31000, 6);

    // R4: ratio write restarts the phase
    curTag = "R4 phase restart";
    setFilter(1, 5, 2, 7);
    pushSample(1000, 2000, 4);
    writeCfg(258, 1);
    pushSample(3000, 4000, 4);
    pushSample(5000, 6000, 4);

    // R7 rounding, scale 7 and 6
    curTag = "R7 rounding";
    writeCfg(201, 262144);
    setFilter(0, 201, 0, 7);
    pushSample(3, -3, 3);
    pushSample(5, -5, 3);
    writeCfg(259, 6);
    pushSample(6, -6, 3);
    pushSample(2, -2, 3);

    // R8 saturation both ways
    curTag = "R8 clamp";
    writeCfg(200, 524287);
    setFilter(0, 200, 0, 7);
    pushSample(131071, -131072, 3);
    pushSample(-131072, 131071, 3);

    // R10: back-to-back triggers on a running pass
    curTag = "R10 overrun";
    setFilter(7, 0, 0, 7);
    for (int i = 0; i < 12; i++) pushSample(smpI(i + 500), smpQ(i + 500), 0);
    repeat (30) @(negedge clk);
    chk("R9 every expected output seen", qI.size(), 0);
    chk("R10 overrun quiet when idle", int'(overrun), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule